// File: doc/BRIEF.md
# Domain-Based Memory Access Checker

This block sits after address translation and decides, in the same cycle, whether a memory access to a translated region may go ahead. It receives the attribute bits of the region (a 4-bit domain number, a 3-bit permission code and an execute-never flag), the current privilege mode, the kind of access (read, write or instruction fetch) and a 32-bit domain control word holding a 2-bit setting for each of 16 domains.

The check runs in two stages. The first stage looks up the region's domain setting. A domain marked "no access" or "reserved" faults at once. A domain marked "manager" lets the access through without looking at the region permissions or the execute-never flag. A domain marked "client" passes the access to the second stage. There the permission code is decoded against the privilege mode and access kind, and fetches are screened against the execute-never flag. The block returns a combinational allow flag and a 2-bit fault cause.

Domain setting encoding (bits [2n+1:2n] of the control word for domain n): 00 no access, 01 client, 10 reserved (treated as no access), 11 manager. Access kind encoding: 00 read, 01 write, 10 instruction fetch, 11 treated as write. Cause encoding: 00 none, 01 domain fault, 10 permission fault, 11 execute-never fault. Permission codes: 000 none; 001 privileged read-write, user none; 010 privileged read-write, user read-only; 011 read-write for all; 100 reserved (none); 101 privileged read-only, user none; 110 and 111 read-only for all.

Top module: `acc_chk`

## Requirements
- R1: The setting used for an access is the 2-bit field at bits [2n+1:2n] of the domain control word, where n is the region's 4-bit domain number; the fields of the other domains have no effect.
- R2: A domain setting of 00 denies every access with cause 01 (domain fault), whatever the permission code, mode, access kind or execute-never flag.
- R3: A domain setting of 10 behaves exactly as 00: the access is denied with cause 01.
- R4: A domain setting of 11 (manager) allows every access with cause 00, bypassing both the permission code and the execute-never flag.
- R5: Under a client domain (setting 01), a read in privileged mode is allowed for codes 001, 010, 011, 101, 110, 111 and denied with cause 10 for codes 000 and 100.
- R6: Under a client domain, a user-mode read is allowed only for codes 010, 011, 110, 111; codes 001 and 101 (privileged only), 000 and 100 deny it with cause 10.
- R7: Under a client domain, a write is allowed in privileged mode only for codes 001, 010, 011 and in user mode only for code 011; any other write is denied with cause 10.
- R8: Under a client domain, an instruction fetch needs the same permission as a read; when that permission is held and the execute-never flag is 1 the fetch is denied with cause 11, and a missing permission reports cause 10 in preference.
- R9: The execute-never flag has no effect on reads and writes.
- R10: Access kind 11 is judged exactly as a write.
- R11: The allow flag is 1 exactly when the cause is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dom_ctrl_i | input | 32 | Domain control word, 2 bits per domain |
| rgn_dom_i | input | 4 | Domain number of the addressed region |
| rgn_perm_i | input | 3 | Permission code of the region |
| rgn_xn_i | input | 1 | Execute-never flag of the region |
| priv_i | input | 1 | 1 when the access is made in privileged mode |
| kind_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 as write |
| allow_o | output | 1 | Access may proceed |
| cause_o | output | 2 | Fault cause: 00 none, 01 domain, 10 permission, 11 execute-never |

## Verification
A permission failure and an execute-never hit can both be true for one instruction fetch, and a domain fault can coincide with either of them. The bench provokes these overlaps by sweeping every domain setting against every permission code, privilege mode, access kind and execute-never value, with the tested domain moved through all 16 positions and the other fields set to the opposite setting. Each result is judged against a priority order (domain, then permission, then execute-never) computed in the bench from bit arithmetic on the permission code, so an overlap that reports the lower-priority cause, or lets the access through, is caught.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;

  localparam int unsigned NUM_DOM   = 16;
  localparam int unsigned DOM_FLD_W = 2;
  localparam int unsigned DOM_IDX_W = $clog2(NUM_DOM);
  localparam int unsigned CTRL_W    = NUM_DOM * DOM_FLD_W;
  localparam int unsigned PERM_W    = 3;

  typedef enum logic [1:0] {
    DM_BLOCK   = 2'b00,
    DM_CLIENT  = 2'b01,
    DM_RSVD    = 2'b10,
    DM_MANAGER = 2'b11
  } dom_mode_e;

  typedef enum logic [1:0] {
    AK_READ  = 2'b00,
    AK_WRITE = 2'b01,
    AK_FETCH = 2'b10,
    AK_ALTW  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_DOM  = 2'b01,
    FC_PERM = 2'b10,
    FC_XN   = 2'b11
  } fault_e;

  typedef struct packed {
    logic priv_rd;
    logic priv_wr;
    logic user_rd;
    logic user_wr;
  } rights_t;

  // Decode of the 3-bit permission code into the four rights.
  function automatic rights_t decode_perm(input logic [PERM_W-1:0] code);
    rights_t r;
    unique case (code)
      3'b001:          r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b0, user_wr: 1'b0};
      3'b010:          r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b0};
      3'b011:          r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b1};
      3'b101:          r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b0, user_wr: 1'b0};
      3'b110, 3'b111:  r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b1, user_wr: 1'b0};
      default:         r = '{priv_rd: 1'b0, priv_wr: 1'b0, user_rd: 1'b0, user_wr: 1'b0};
    endcase
    return r;
  endfunction

  function automatic logic is_write_kind(input acc_kind_e k);
    return (k == AK_WRITE) || (k == AK_ALTW);
  endfunction

endpackage

// File: rtl/acc_dom_sel.sv
module acc_dom_sel
  import acc_chk_pkg::*;
#(
  parameter int unsigned N_DOM = NUM_DOM,
  parameter int unsigned FLD_W = DOM_FLD_W
) (
  input  logic [N_DOM*FLD_W-1:0]     ctrl_i,
  input  logic [$clog2(N_DOM)-1:0]   dom_i,
  output dom_mode_e                  mode_o,
  output logic                       dom_fault_o,
  output logic                       bypass_o
);

  logic [FLD_W-1:0] fld [N_DOM];

  for (genvar g = 0; g < N_DOM; g++) begin : g_unpack
    assign fld[g] = ctrl_i[g*FLD_W +: FLD_W];
  end

  assign mode_o      = dom_mode_e'(fld[dom_i]);
  assign dom_fault_o = (mode_o == DM_BLOCK) || (mode_o == DM_RSVD);
  assign bypass_o    = (mode_o == DM_MANAGER);

  always_comb begin
    if (!$isunknown({ctrl_i, dom_i})) begin
      AST_DOM_EXCLUSIVE: assert (!(dom_fault_o && bypass_o)); // R4
      AST_RSVD_BLOCKS: assert (!(mode_o == DM_RSVD) || dom_fault_o); // R3
    end
  end

endmodule

// File: rtl/acc_perm_eval.sv
module acc_perm_eval
  import acc_chk_pkg::*;
#(
  parameter int unsigned P_W = PERM_W
) (
  input  logic [P_W-1:0] perm_i,
  input  logic           priv_i,
  input  acc_kind_e      kind_i,
  input  logic           xn_i,
  output logic           perm_fail_o,
  output logic           xn_hit_o
);

  rights_t rights;
  logic    need_wr;
  logic    granted;

  assign rights  = decode_perm(perm_i);
  assign need_wr = is_write_kind(kind_i);

  always_comb begin
    if (need_wr) granted = priv_i ? rights.priv_wr : rights.user_wr;
    else         granted = priv_i ? rights.priv_rd : rights.user_rd;
  end

  assign perm_fail_o = !granted;
  assign xn_hit_o    = xn_i && (kind_i == AK_FETCH);

  always_comb begin
    if (!$isunknown({perm_i, priv_i, kind_i, xn_i})) begin
      AST_USER_WR_ONLY_RW: assert (!(need_wr && !priv_i && !perm_fail_o) || perm_i == 3'b011); // R7
      AST_PRIV_ONLY_USER_DENY: assert (!(!priv_i && (perm_i == 3'b001 || perm_i == 3'b101)) || perm_fail_o); // R6
      AST_XN_FETCH_ONLY: assert (!xn_hit_o || kind_i == AK_FETCH); // R9
    end
  end

endmodule

// File: rtl/acc_chk.sv
module acc_chk
  import acc_chk_pkg::*;
(
  input  logic [31:0] dom_ctrl_i,
  input  logic [3:0]  rgn_dom_i,
  input  logic [2:0]  rgn_perm_i,
  input  logic        rgn_xn_i,
  input  logic        priv_i,
  input  logic [1:0]  kind_i,
  output logic        allow_o,
  output logic [1:0]  cause_o
);

  dom_mode_e dom_mode;
  logic      dom_fault;
  logic      dom_bypass;
  logic      perm_fail;
  logic      xn_hit;
  fault_e    cause;

  acc_dom_sel #(
    .N_DOM (NUM_DOM),
    .FLD_W (DOM_FLD_W)
  ) u_dom (
    .ctrl_i      (dom_ctrl_i),
    .dom_i       (rgn_dom_i),
    .mode_o      (dom_mode),
    .dom_fault_o (dom_fault),
    .bypass_o    (dom_bypass)
  );

  acc_perm_eval #(
    .P_W (PERM_W)
  ) u_perm (
    .perm_i      (rgn_perm_i),
    .priv_i      (priv_i),
    .kind_i      (acc_kind_e'(kind_i)),
    .xn_i        (rgn_xn_i),
    .perm_fail_o (perm_fail),
    .xn_hit_o    (xn_hit)
  );

  // Priority: domain fault, manager bypass, permission, execute-never.
  always_comb begin
    if (dom_fault)       cause = FC_DOM;
    else if (dom_bypass) cause = FC_NONE;
    else if (perm_fail)  cause = FC_PERM;
    else if (xn_hit)     cause = FC_XN;
    else                 cause = FC_NONE;
  end

  assign cause_o = cause;
  assign allow_o = (cause == FC_NONE);

  always_comb begin
    if (!$isunknown({dom_ctrl_i, rgn_dom_i, rgn_perm_i, rgn_xn_i, priv_i, kind_i})) begin
      AST_BLOCK_DENIES: assert (!dom_fault || (!allow_o && cause_o == 2'b01)); // R2
      AST_MANAGER_ALLOWS: assert (!(dom_mode == DM_MANAGER) || allow_o); // R4
      AST_PERM_BEFORE_XN: assert (!(dom_mode == DM_CLIENT && perm_fail) || cause_o == 2'b10); // R8
      AST_ALLOW_MATCHES_CAUSE: assert (allow_o == (cause_o == 2'b00)); // R11
    end
  end

endmodule

// File: tb/acc_chk_tb.sv
module acc_chk_tb;

  logic        clk = 1'b0;
  logic [31:0] dom_ctrl;
  logic [3:0]  rgn_dom;
  logic [2:0]  rgn_perm;
  logic        rgn_xn;
  logic        priv;
  logic [1:0]  kind;
  logic        allow;
  logic [1:0]  cause;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  acc_chk u_dut (
    .dom_ctrl_i (dom_ctrl),
    .rgn_dom_i  (rgn_dom),
    .rgn_perm_i (rgn_perm),
    .rgn_xn_i   (rgn_xn),
    .priv_i     (priv),
    .kind_i     (kind),
    .allow_o    (allow),
    .cause_o    (cause)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // Expected cause by bit arithmetic on the permission code.
  function automatic logic [1:0] model(input logic [1:0] fld, input logic [2:0] p,
                                       input logic pv, input logic [1:0] k, input logic x);
    logic [1:0] ap;
    logic rd_ok, wr_ok, ok;
    ap = p[1:0];
    if (fld == 2'b00 || fld == 2'b10) return 2'b01;
    if (fld == 2'b11) return 2'b00;
    rd_ok = pv ? (ap != 2'b00 && p != 3'b100) : ap[1];
    wr_ok = pv ? (!p[2] && ap != 2'b00) : (p == 3'b011);
    ok    = k[0] ? wr_ok : rd_ok;
    if (!ok) return 2'b10;
    if (k == 2'b10 && x) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [1:0] exp_c);
    @(negedge clk);
    n_chk++;
    if (cause !== exp_c || allow !== (exp_c == 2'b00)) begin
      n_bad++;
      $display("FAIL %s: dom=%0d perm=%b priv=%b kind=%b xn=%b ctrl=%h actual allow=%b cause=%b expected allow=%b cause=%b",
               tag, rgn_dom, rgn_perm, priv, kind, rgn_xn, dom_ctrl, allow, cause,
               (exp_c == 2'b00), exp_c);
    end
    n_chk++;
    if (allow !== (cause == 2'b00)) begin
      n_bad++;
      $display("FAIL R11: actual allow=%b cause=%b expected allow=%b", allow, cause, cause == 2'b00);
    end
  endtask

  function automatic string pick_tag(input logic [1:0] fld, input logic pv,
                                     input logic [1:0] k, input logic x);
    if (fld == 2'b00) return "R2";
    if (fld == 2'b10) return "R3";
    if (fld == 2'b11) return "R4";
    if (k == 2'b11)   return "R10";
    if (k == 2'b10)   return "R8";
    if (x)            return "R9";
    if (k == 2'b01)   return "R7";
    if (!pv)          return "R6";
    return "R5";
  endfunction

  initial begin
    logic [31:0] lfsr;
    dom_ctrl = '0; rgn_dom = '0; rgn_perm = '0; rgn_xn = 1'b0; priv = 1'b0; kind = '0;
    @(posedge clk);
    // Reset-state style check: all-zero control word blocks domain 0 (R2).
    check("R2", 2'b01);

    // Main sweep: every setting x code x mode x kind x xn, domain position rotating (R1..R10).
    for (int f = 0; f < 4; f++)
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 2; m++)
          for (int k = 0; k < 4; k++)
            for (int x = 0; x < 2; x++) begin
              int d;
              logic [1:0] other;
              d = (p * 8 + m * 4 + k * 2 + x + f) % 16;
              other = (f == 3) ? 2'b00 : 2'b11;
              @(posedge clk);
              for (int i = 0; i < 16; i++) dom_ctrl[2*i +: 2] = (i == d) ? f[1:0] : other;
              rgn_dom  = d[3:0];
              rgn_perm = p[2:0];
              priv     = m[0];
              kind     = k[1:0];
              rgn_xn   = x[0];
              check(pick_tag(f[1:0], m[0], k[1:0], x[0]),
                    model(f[1:0], p[2:0], m[0], k[1:0], x[0]));
            end

    // Domain lookup sweep with pseudo-random control words (R1).
    lfsr = 32'hACE1_1234;
    for (int r = 0; r < 24; r++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      for (int d = 0; d < 16; d++) begin
        @(posedge clk);
        dom_ctrl = lfsr;
        rgn_dom  = d[3:0];
        rgn_perm = 3'b101;
        priv     = 1'b0;
        kind     = 2'b00;
        rgn_xn   = 1'b1;
        check("R1", model(lfsr[2*d +: 2], 3'b101, 1'b0, 2'b00, 1'b1));
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule